// File: doc/BRIEF.md
# Bit-serial two's-complement subtracter

This block forms the difference of two two's-complement words that arrive one bit per clock, least significant bit first, on two single-bit lines: one line carries the minuend and the other the subtrahend. It is a serial adder with a single carry flop. Each subtrahend bit is complemented on its way in, and a carry of one is forced into the adder on the first bit time of the word. Together these two steps negate the subtrahend.

Two strobes frame the work. A period strobe is held high for every bit time of a subtraction. A first-bit strobe is high only on the rightmost (least significant) digit. While the period strobe is low, both operands count as zero, the carry flop is cleared and the output stream is 0. The difference leaves on one line, bit by bit, after three register stages: capture, sum and output.

The arithmetic is modulo 2^N. The carry out of the most significant bit is dropped, and neither the sign digit (0 non-negative, 1 negative) nor the position of the binary point needs special handling. Words may follow one another with no gap: the period strobe stays high and the first-bit strobe marks the start of the next word.

Top module: `serial_subtracter`

## Requirements
- R1: For a word presented with the first-bit strobe on its least significant bit, the output stream carries (minuend − subtrahend) mod 2^N, least significant bit first.
- R2: The output bit that belongs to the input bits sampled at rising edge e is visible on `diff_bit` just after rising edge e+2, that is after three register stages.
- R3: Any bit time sampled with `period_en` low yields a 0 on `diff_bit` at its output time, whatever the data lines carry.
- R4: The carry flop is cleared while `period_en` is low. A period that follows an idle bit time and has no first-bit strobe therefore computes minuend + complement(subtrahend) with a zero starting carry, giving (minuend − subtrahend − 1) mod 2^N.
- R5: Words sent back to back, with `period_en` kept high and `first_bit` on each word's first bit, are each computed independently: the carry out of a word's most significant bit does not reach the next word.
- R6: The reset is synchronous and active low. While it is applied, and for the bit times captured during it, `diff_bit` is 0.
- R7: The result is correct across the sign boundary: a difference outside the signed range wraps modulo 2^N (for example, with N = 4, −8 − 1 gives +7, code 0111).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| period_en | input | 1 | High for every bit time of a subtraction |
| first_bit | input | 1 | High on the least significant bit of a word |
| min_bit | input | 1 | Minuend serial data, LSB first |
| sub_bit | input | 1 | Subtrahend serial data, LSB first |
| diff_bit | output | 1 | Difference serial data, LSB first, three stages late |

## Verification
The assertions assume well-formed framing. `first_bit` is only raised while `period_en` is high, and only on the first bit time of a period or exactly WORD_W bit times after the previous word began. The stimulus keeps to this: every word is exactly WORD_W bits long, and it is preceded either by an idle bit time or directly by the previous word. The one deliberate departure from normal framing is a period with no first-bit strobe at all, which those assumptions allow. It is always preceded by an idle bit time, so the expected result follows from a cleared carry.

// File: rtl/serial_sub_pkg.sv
// Package: shared types for the bit-serial subtracter.
// Assumes: single-bit serial operands, one bit per clock.
package serial_sub_pkg;

    // Operand bits after capture; all fields are zero when idle.
    typedef struct packed {
        logic en;    // bit time belongs to an active period
        logic inj;   // force carry-in of one (first bit of a word)
        logic a;     // minuend bit
        logic b;     // complemented subtrahend bit
    } opnd_t;

endpackage

// File: rtl/sub_operand_stage.sv
// Module: sub_operand_stage
// Registers the serial operands for one bit time. It complements the
// subtrahend and gates every field with the period strobe, so an idle
// bit time reaches the adder as all zeros.
// Assumes: first_bit is only meaningful while period_en is high.
module sub_operand_stage
    import serial_sub_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  period_en,
    input  logic  first_bit,
    input  logic  min_bit,
    input  logic  sub_bit,
    output opnd_t opnd_q
);

    // Capture the gated, complemented operands for the adder stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
        end else if (!period_en) begin
            opnd_q <= '0;
        end else begin
            opnd_q.en  <= 1'b1;
            opnd_q.inj <= first_bit;
            opnd_q.a   <= min_bit;
            opnd_q.b   <= ~sub_bit;
        end
    end

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_en |=> (opnd_q == '0));

    // R1
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_en |=> (opnd_q.b != $past(sub_bit)));

endmodule

// File: rtl/sub_serial_adder.sv
// Module: sub_serial_adder
// A one-bit full adder with a single carry flop. Its carry-in is forced
// to one on an injected bit time, and the carry flop is cleared on idle
// bit times. The sum bit is registered.
// Assumes: operands come from sub_operand_stage (zero when idle).
module sub_serial_adder
    import serial_sub_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  opnd_t opnd_q,
    output logic  sum_q
);

    logic carry_q;
    logic cin_w;
    logic sum_w;
    logic cout_w;

    // Combine the injected unit and the stored carry into one carry-in.
    always_comb begin
        cin_w  = opnd_q.en & (opnd_q.inj | carry_q);
        sum_w  = opnd_q.a ^ opnd_q.b ^ cin_w;
        cout_w = (opnd_q.a & opnd_q.b) | (cin_w & (opnd_q.a ^ opnd_q.b));
    end

    // Keep the carry for the next bit; clear it on idle bit times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (!opnd_q.en) begin
            carry_q <= 1'b0;
        end else begin
            carry_q <= cout_w;
        end
    end

    // Register the sum bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= 1'b0;
        end else begin
            sum_q <= sum_w;
        end
    end

    // R4
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !opnd_q.en |=> !carry_q);

    // R1
    inject_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_q.inj && (opnd_q.a || opnd_q.b)) |=> carry_q);

    // R3
    idle_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !opnd_q.en |=> !sum_q);

endmodule

// File: rtl/sub_out_delay.sv
// Module: sub_out_delay
// A shift register of STAGES flops on the serial output line.
// Assumes: STAGES >= 1.
module sub_out_delay #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] pipe_q;

    // Shift the serial bit one place per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign dout = pipe_q[STAGES-1];

    initial begin
        // R2
        stages_chk: assert (STAGES >= 1);
    end

endmodule

// File: rtl/serial_subtracter.sv
// Module: serial_subtracter (top)
// Bit-serial two's-complement subtracter: diff = min - sub mod 2^WORD_W,
// LSB first. The output is 2 + OUT_STAGES register stages late
// (3 by default).
// Assumes: first_bit is raised only inside a period, on a word's first bit.
module serial_subtracter
    import serial_sub_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int OUT_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_en,
    input  logic first_bit,
    input  logic min_bit,
    input  logic sub_bit,
    output logic diff_bit
);

    localparam int LATENCY = 2 + OUT_STAGES;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int IDLE_W  = $clog2(LATENCY + 1);

    opnd_t opnd_q;
    logic  sum_q;

    sub_operand_stage u_opnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_en (period_en),
        .first_bit (first_bit),
        .min_bit   (min_bit),
        .sub_bit   (sub_bit),
        .opnd_q    (opnd_q)
    );

    sub_serial_adder u_add (
        .clk    (clk),
        .rst_n  (rst_n),
        .opnd_q (opnd_q),
        .sum_q  (sum_q)
    );

    sub_out_delay #(.STAGES(OUT_STAGES)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sum_q),
        .dout  (diff_bit)
    );

    // Checker state: bits since word start, and the run of idle bit times.
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [IDLE_W-1:0] idle_run_q;

    // Count bits in the current word, saturating at WORD_W.
    always_ff @(posedge clk) begin
        if (!rst_n || !period_en) begin
            bit_cnt_q <= '0;
        end else if (first_bit) begin
            bit_cnt_q <= CNT_W'(1);
        end else if (bit_cnt_q != CNT_W'(WORD_W)) begin
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
        end
    end

    // Count consecutive idle bit times, saturating at LATENCY.
    always_ff @(posedge clk) begin
        if (!rst_n || period_en) begin
            idle_run_q <= '0;
        end else if (idle_run_q != IDLE_W'(LATENCY)) begin
            idle_run_q <= idle_run_q + IDLE_W'(1);
        end
    end

    // R1
    first_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_bit |-> period_en);

    // R5
    word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_en && first_bit) |->
            (bit_cnt_q == '0 || bit_cnt_q == CNT_W'(WORD_W)));

    // R3
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_run_q == IDLE_W'(LATENCY)) |-> !diff_bit);

endmodule

// File: tb/test_serial_subtracter.sv
// Bench: exhaustive sweep of all operand pairs at WORD_W = 4.
module test_serial_subtracter;

    localparam int N    = 4;
    localparam int MASK = (1 << N) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic period_en = 1'b0;
    logic first_bit = 1'b0;
    logic min_bit = 1'b0;
    logic sub_bit = 1'b0;
    logic diff_bit;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // expected-bit pipeline: index 2 is due at the current negedge
    logic  ex_bit [0:2];
    bit    ex_vld [0:2];
    string ex_req [0:2];
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    serial_subtracter #(.WORD_W(N), .OUT_STAGES(1)) i_serial_subtracter (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_en (period_en),
        .first_bit (first_bit),
        .min_bit   (min_bit),
        .sub_bit   (sub_bit),
        .diff_bit  (diff_bit)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: diff_bit=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One bit time: check the bit due now, then drive the next inputs.
    task automatic step(input logic r, input logic p, input logic f,
                        input logic m, input logic s, input logic e,
                        input string req);
        @(negedge clk);
        if (ex_vld[2]) check(diff_bit, ex_bit[2], ex_req[2]);
        ex_bit[2] = ex_bit[1]; ex_vld[2] = ex_vld[1]; ex_req[2] = ex_req[1];
        ex_bit[1] = ex_bit[0]; ex_vld[1] = ex_vld[0]; ex_req[1] = ex_req[0];
        ex_bit[0] = e;         ex_vld[0] = 1'b1;      ex_req[0] = req;
        rst_n = r; period_en = p; first_bit = f; min_bit = m; sub_bit = s;
    endtask

    task automatic rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Idle bit times with random data lines; expected output 0 (R3).
    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            rnd();
            step(1'b1, 1'b0, 1'b0, lfsr[0], lfsr[1], 1'b0, req);
        end
    endtask

    // A word of N bits; inj selects the first-bit strobe.
    task automatic send_word(input int m, input int s, input bit inj, input string req);
        int d;
        d = (m - s - (inj ? 0 : 1)) & MASK;
        for (int k = 0; k < N; k++) begin
            step(1'b1, 1'b1, inj && (k == 0), m[k], s[k], d[k], req);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            ex_vld[i] = 1'b0; ex_bit[i] = 1'b0; ex_req[i] = "";
        end
        // R6: reset held with an active-looking period; output must stay 0
        for (int i = 0; i < 6; i++) begin
            rnd();
            step(1'b0, 1'b1, 1'b0, lfsr[2], lfsr[3], 1'b0, "R6");
        end
        idle(3, "R6");

        // R1: every operand pair, each word preceded by an idle bit time
        for (int m = 0; m <= MASK; m++) begin
            for (int s = 0; s <= MASK; s++) begin
                idle(1, "R3");
                send_word(m, s, 1'b1, "R1");
            end
        end
        idle(3, "R3");

        // R5: every pair again, back to back with no gap
        for (int m = 0; m <= MASK; m++) begin
            for (int s = 0; s <= MASK; s++) begin
                send_word(m, s, 1'b1, "R5");
            end
        end
        idle(2, "R3");

        // R2: one set bit after idle; the output must be exactly aligned
        send_word(1, 0, 1'b1, "R2");
        send_word(0, 15, 1'b1, "R2");
        idle(4, "R2");

        // R4: no first-bit strobe after idle -> m - s - 1
        send_word(5, 3, 1'b0, "R4");
        idle(1, "R4");
        send_word(0, 0, 1'b0, "R4");
        idle(1, "R4");
        send_word(9, 12, 1'b0, "R4");
        idle(2, "R4");

        // R7: sign boundary wrap-around (-8 - 1 = +7, 7 - (-1) = -8)
        send_word(8, 1, 1'b1, "R7");
        send_word(7, 15, 1'b1, "R7");
        send_word(8, 8, 1'b1, "R7");
        idle(4, "R7");

        // R3: a long idle stretch with noisy data lines
        idle(20, "R3");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule